// File: doc/BRIEF.md
# NAND Page and Block Semantics Emulator

This block is an on-chip memory that follows the access rules of a small NAND flash die. Storage is split into blocks, and every block into pages. Each page holds a data area plus a smaller spare area for metadata, and the two are always moved together as one wide word. A command port accepts three operations: page read, page program and block erase. A busy/done pair reports when each command has finished.

Program can only pull bits from 1 to 0, so the stored page becomes the bitwise AND of its old contents and the write word. A program that asks for a 0-to-1 change raises a violation flag, but the AND result is still written. Only a block erase brings bits back to 1. Every block keeps its own erase count. When that count reaches the endurance limit the block is marked worn out, and further program or erase commands to it are refused with an error flag. Reads of a worn-out block are still allowed.

Firmware models, flash-translation-layer logic and test benches can use this block as a cheap stand-in for a real die. They issue one command, wait for done, then read the result or flags.

Top module: `nand_page_store`

## Requirements
- R1: After reset, busy, done, both error flags, every erase count and the worn-out map are 0, rdata is 0, and every page reads back all ones.
- R2: An accepted read (cmd_op = 0) places the addressed page, data and spare area together, on rdata. It appears one cycle after acceptance and holds until the next accepted read.
- R3: An accepted program (cmd_op = 1) to a block that is not worn out replaces the whole addressed page with the AND of its old contents and cmd_wdata.
- R4: A program whose cmd_wdata has a 1 where the page holds a 0 sets err_viol, and the AND result is still stored. err_viol and err_bad are never both set.
- R5: An accepted erase (cmd_op = 2) to a block that is not worn out sets every page of that block to all ones. Pages of other blocks do not change.
- R6: Each successful erase adds one to that block's count. The count of the block chosen by wear_sel appears on wear_cnt, and no count exceeds ENDURANCE.
- R7: A block whose count equals ENDURANCE shows 1 in its bad_map bit, and that bit stays set. A program or erase to such a block sets err_bad and changes neither its contents nor its count. Reads of it still work.
- R8: Busy is high for exactly T_RD, T_PG or T_ER cycles (defaults 1, 4, 16), starting the cycle after acceptance. Done is high only in the last busy cycle, and busy falls right after it.
- R9: A command is accepted when cmd_valid is high, busy is low and cmd_op is not 3. Commands presented while busy is high have no effect.
- R10: Op code 3 is never accepted: it raises no busy and changes no state.
- R11: Both error flags are recomputed on every accepted command and hold their value between accepted commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 read, 1 program, 2 erase, 3 ignored |
| cmd_blk | input | log2(NBLK) | Block address |
| cmd_page | input | log2(NPG) | Page address within the block |
| cmd_wdata | input | (DBYTES+SBYTES)*8 | Program word, data and spare area |
| busy | output | 1 | Command in progress |
| done | output | 1 | Single-cycle completion pulse |
| rdata | output | (DBYTES+SBYTES)*8 | Last page read |
| err_bad | output | 1 | Last command refused: block worn out |
| err_viol | output | 1 | Last program asked for a 0-to-1 change |
| wear_sel | input | log2(NBLK) | Block whose erase count is shown |
| wear_cnt | output | log2(ENDURANCE+1) | Erase count of the selected block |
| bad_map | output | NBLK | One worn-out bit per block |

## Verification
The assertions check the handshake shape on every cycle: done only inside busy, a single-cycle done, busy starting after an accepted command and not after op 3, and flags frozen while busy. They also check that worn-out bits never clear, that erase counts stay within the limit, and that the two error flags are never both set. The AND-only program rule, block-wide erase, the independence of other blocks and the refusal of commands to worn-out blocks depend on stored contents. Only the bench's scenarios, compared against its behavioural model, can show those.

// File: rtl/nand_page_store.sv
module nand_page_store #(
  parameter int NBLK      = 8,
  parameter int NPG       = 4,
  parameter int DBYTES    = 16,
  parameter int SBYTES    = 4,
  parameter int ENDURANCE = 1000,
  parameter int T_RD      = 1,
  parameter int T_PG      = 4,
  parameter int T_ER      = 16,
  localparam int BAW  = $clog2(NBLK),
  localparam int PAW  = $clog2(NPG),
  localparam int PW   = (DBYTES + SBYTES) * 8,
  localparam int CW   = $clog2(ENDURANCE + 1),
  localparam int TMAX = (T_ER > T_PG) ? ((T_ER > T_RD) ? T_ER : T_RD) : ((T_PG > T_RD) ? T_PG : T_RD),
  localparam int TW   = $clog2(TMAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd_op,
  input  logic [BAW-1:0] cmd_blk,
  input  logic [PAW-1:0] cmd_page,
  input  logic [PW-1:0]  cmd_wdata,
  output logic           busy,
  output logic           done,
  output logic [PW-1:0]  rdata,
  output logic           err_bad,
  output logic           err_viol,
  input  logic [BAW-1:0] wear_sel,
  output logic [CW-1:0]  wear_cnt,
  output logic [NBLK-1:0] bad_map
);
  localparam logic [1:0] OP_RD = 2'd0;
  localparam logic [1:0] OP_PG = 2'd1;
  localparam logic [1:0] OP_ER = 2'd2;
  localparam int NPAGES = NBLK * NPG;

  logic [PW-1:0] mem  [NPAGES];
  logic [CW-1:0] wear [NBLK];
  logic [TW-1:0] tmr;

  wire               accept = cmd_valid && (tmr == '0) && (cmd_op != 2'd3);
  wire [BAW+PAW-1:0] idx    = {cmd_blk, cmd_page};
  wire [PW-1:0]      cur    = mem[idx];
  wire               worn   = bad_map[cmd_blk];
  wire               do_pg  = accept && cmd_op == OP_PG && !worn;
  wire               do_er  = accept && cmd_op == OP_ER && !worn;

  assign busy     = tmr != '0;
  assign done     = tmr == TW'(1);
  assign wear_cnt = wear[wear_sel];

  for (genvar b = 0; b < NBLK; b++) begin : g_bad
    assign bad_map[b] = wear[b] >= CW'(ENDURANCE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      tmr <= '0;
    else if (accept)
      tmr <= (cmd_op == OP_RD) ? TW'(T_RD) : (cmd_op == OP_PG) ? TW'(T_PG) : TW'(T_ER);
    else if (tmr != '0)
      tmr <= tmr - TW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      err_bad  <= 1'b0;
      err_viol <= 1'b0;
    end else if (accept) begin
      err_bad  <= (cmd_op != OP_RD) && worn;
      err_viol <= (cmd_op == OP_PG) && !worn && (|(~cur & cmd_wdata));
      if (cmd_op == OP_RD)
        rdata <= cur;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAGES; i++)
        mem[i] <= '1;
    end else if (do_pg) begin
      mem[idx] <= cur & cmd_wdata;
    end else if (do_er) begin
      for (int p = 0; p < NPG; p++)
        mem[{cmd_blk, PAW'(p)}] <= '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++)
        wear[b] <= '0;
    end else if (do_er) begin
      wear[cmd_blk] <= wear[cmd_blk] + CW'(1);
    end
  end
endmodule

// File: rtl/nand_page_store_chk.sv
module nand_page_store_chk #(
  parameter int NBLK = 8,
  parameter int CW   = 10,
  parameter int ENDURANCE = 1000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [1:0]      cmd_op,
  input logic            busy,
  input logic            done,
  input logic            err_bad,
  input logic            err_viol,
  input logic [CW-1:0]   wear_cnt,
  input logic [NBLK-1:0] bad_map
);
  a_r8_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
  a_r8_done_single:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r8_busy_holds:   assert property (@(posedge clk) disable iff (!rst_n) busy && !done |=> busy);
  a_r8_release:      assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  a_r9_start:        assert property (@(posedge clk) disable iff (!rst_n)
                       !busy && cmd_valid && cmd_op != 2'd3 |=> busy);
  a_r10_idle_stays:  assert property (@(posedge clk) disable iff (!rst_n)
                       !busy && !(cmd_valid && cmd_op != 2'd3) |=> !busy);
  a_r11_flags_hold:  assert property (@(posedge clk) disable iff (!rst_n)
                       busy |=> $stable(err_bad) && $stable(err_viol));
  a_r4_flag_excl:    assert property (@(posedge clk) disable iff (!rst_n) !(err_viol && err_bad));
  a_r6_wear_cap:     assert property (@(posedge clk) disable iff (!rst_n) wear_cnt <= CW'(ENDURANCE));
  a_r7_bad_sticky:   assert property (@(posedge clk) disable iff (!rst_n)
                       1'b1 |=> (bad_map & $past(bad_map)) == $past(bad_map));
endmodule

bind nand_page_store nand_page_store_chk #(.NBLK(NBLK), .CW(CW), .ENDURANCE(ENDURANCE)) u_chk (.*);

// File: tb/sim_nand_page_store.sv
module sim_nand_page_store;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8, NP = 4, PW = 160, CW = 2, END = 3;
  localparam int TR = 1, TP = 4, TE = 16;

  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [2:0] cmd_blk = 0, wear_sel = 0;
  logic [1:0] cmd_page = 0;
  logic [PW-1:0] cmd_wdata = '0, rdata;
  logic busy, done, err_bad, err_viol;
  logic [CW-1:0] wear_cnt;
  logic [NB-1:0] bad_map;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_page_store #(.ENDURANCE(END)) u0 (.*);

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [PW-1:0] m_mem [NB*NP];
  int m_wear [NB];
  int m_tmr;
  logic [PW-1:0] m_rd;
  bit m_eb, m_ev, live = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = '1;
      foreach (m_wear[i]) m_wear[i] = 0;
      m_tmr = 0; m_rd = '0; m_eb = 0; m_ev = 0; live = 1;
    end else begin
      int k;
      bit wornb;
      k = cmd_blk * NP + cmd_page;
      wornb = m_wear[cmd_blk] >= END;
      if (m_tmr > 0) m_tmr--;
      else if (cmd_valid && cmd_op != 3) begin
        m_tmr = (cmd_op == 0) ? TR : (cmd_op == 1) ? TP : TE;
        m_eb = (cmd_op != 0) && wornb;
        m_ev = 0;
        case (cmd_op)
          0: m_rd = m_mem[k];
          1: if (!wornb) begin
               m_ev = |(~m_mem[k] & cmd_wdata);
               m_mem[k] = m_mem[k] & cmd_wdata;
             end
          default: if (!wornb) begin
               for (int p = 0; p < NP; p++) m_mem[cmd_blk*NP+p] = '1;
               m_wear[cmd_blk]++;
             end
        endcase
      end
    end
  end

  always @(negedge clk) if (live) begin
    logic [NB-1:0] mb;
    for (int b = 0; b < NB; b++) mb[b] = m_wear[b] >= END;
    chk(busy == (m_tmr > 0), "R8 busy", PW'(busy), PW'(m_tmr > 0));
    chk(done == (m_tmr == 1), "R8 done", PW'(done), PW'(m_tmr == 1));
    chk(rdata === m_rd, "R2 rdata", rdata, m_rd);
    chk(err_bad == m_eb, "R7 err_bad", PW'(err_bad), PW'(m_eb));
    chk(err_viol == m_ev, "R4 err_viol", PW'(err_viol), PW'(m_ev));
    chk(bad_map == mb, "R7 bad_map", PW'(bad_map), PW'(mb));
    chk(wear_cnt == CW'(m_wear[wear_sel]), "R6 wear_cnt", PW'(wear_cnt), PW'(m_wear[wear_sel]));
  end

  int nbusy, ndone;
  task automatic run(input logic [1:0] op, input int b, input int p, input logic [PW-1:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_blk = 3'(b); cmd_page = 2'(p); cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0;
    nbusy = 0; ndone = 0;
    while (busy) begin
      nbusy++;
      if (done) ndone++;
      @(negedge clk);
    end
  endtask

  localparam logic [PW-1:0] ONES = '1;
  localparam logic [PW-1:0] PA = {5{32'hA5F0_3C96}};
  localparam logic [PW-1:0] PB = {5{32'h5AFF_0F69}};
  localparam logic [PW-1:0] PC = {5{32'h1234_8765}};

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && err_bad == 0 && err_viol == 0 && bad_map == 0 && rdata == 0,
            "R1 reset outputs", rdata, '0);
        rst_n = 1;
        run(0, 5, 3, '0);
        chk(rdata == ONES, "R1 erased after reset", rdata, ONES);
        chk(nbusy == TR && ndone == 1, "R8 read length", PW'(nbusy), PW'(TR));

        run(1, 0, 1, PA);
        chk(nbusy == TP && ndone == 1, "R8 program length", PW'(nbusy), PW'(TP));
        run(0, 0, 1, '0);
        chk(rdata == PA, "R3 program stores", rdata, PA);
        run(1, 0, 1, PB);
        chk(err_viol == 1, "R4 violation flagged", PW'(err_viol), 1);
        run(0, 0, 1, '0);
        chk(rdata == (PA & PB), "R4 AND stored", rdata, PA & PB);
        chk(err_viol == 0, "R11 flags cleared on read", PW'(err_viol), 0);
        run(1, 0, 1, PA & PB & PC);
        chk(err_viol == 0, "R4 no violation on clearing only", PW'(err_viol), 0);

        run(1, 1, 2, PC);
        run(1, 0, 3, PB);
        run(2, 0, 0, '0);
        chk(nbusy == TE && ndone == 1, "R8 erase length", PW'(nbusy), PW'(TE));
        run(0, 0, 1, '0);
        chk(rdata == ONES, "R5 erased page 1", rdata, ONES);
        run(0, 0, 3, '0);
        chk(rdata == ONES, "R5 erased page 3", rdata, ONES);
        run(0, 1, 2, '0);
        chk(rdata == PC, "R5 other block kept", rdata, PC);
        wear_sel = 0; @(negedge clk);
        chk(wear_cnt == 1, "R6 count after erase", PW'(wear_cnt), 1);
        wear_sel = 1; @(negedge clk);
        chk(wear_cnt == 0, "R6 other block count", PW'(wear_cnt), 0);

        // commands while busy
        @(negedge clk);
        cmd_valid = 1; cmd_op = 1; cmd_blk = 1; cmd_page = 0; cmd_wdata = PA;
        @(negedge clk);
        cmd_op = 2; cmd_blk = 1;
        @(negedge clk);
        @(negedge clk);
        cmd_valid = 0;
        while (busy) @(negedge clk);
        chk(wear_cnt == 0, "R9 busy erase ignored", PW'(wear_cnt), 0);
        run(0, 1, 0, '0);
        chk(rdata == PA, "R9 program kept", rdata, PA);

        // op 3
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3; cmd_blk = 1; cmd_page = 0;
        @(negedge clk);
        chk(busy == 0, "R10 op3 no busy", PW'(busy), 0);
        cmd_valid = 0;
        @(negedge clk);
        chk(rdata == PA && busy == 0, "R10 op3 no effect", rdata, PA);

        // wear out block 2
        run(1, 2, 0, PB);
        for (int i = 0; i < END; i++) run(2, 2, 0, '0);
        wear_sel = 2; @(negedge clk);
        chk(bad_map[2] == 1 && wear_cnt == CW'(END), "R7 block worn", PW'(wear_cnt), PW'(END));
        run(1, 2, 0, PC);
        chk(err_bad == 1 && err_viol == 0, "R7 program refused", PW'(err_bad), 1);
        run(2, 2, 0, '0);
        chk(err_bad == 1 && wear_cnt == CW'(END), "R7 erase refused", PW'(wear_cnt), PW'(END));
        run(0, 2, 0, '0);
        chk(rdata == ONES && err_bad == 0, "R7 read allowed", rdata, ONES);
        chk(bad_map == 8'b0000_0100, "R7 only block 2 worn", PW'(bad_map), 4);
        repeat (3) @(negedge clk);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R8 watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule